// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block recovers characters from an asynchronous serial line and keeps the status flags that go with them. The line is taken either from an external receive pin or, when loopback is selected, from the local transmitter's output. The receive pin is passed through a two-flop synchroniser. A 16x oversampling tick comes from a programmable divisor. Character length, parity mode and forced ("stick") parity come in as run-time control fields, which the block shares with the transmitter.

Each finished character is stored in a one-byte buffer. Alongside the buffer the block keeps six status outputs: data ready, parity error, overrun, framing error, break detected and a line-error interrupt level. The register bus decode places two single-cycle read strobes, one for the buffer and one for the status register. The buffer strobe clears the data-ready flag. The status strobe clears the error and break flags. Interrupt logic uses the line-error level.

Top module: `serial_rx_top`

## Requirements
- R1: After reset, data_ready, parity_err, overrun_err, framing_err, break_det and line_err_irq are all 0.
- R2: char_len selects the number of data bits: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Data bits arrive least significant bit first. The received character appears right-aligned on rx_data, with the unused upper bits at 0.
- R3: A falling edge on the line starts a frame. The frame is accepted only if the line is still 0 when sampled 8 ticks later. Later bits are sampled every 16 ticks. A low pulse shorter than half a bit is ignored and leaves data_ready at 0.
- R4: With parity_en=1 and stick_par=0, the parity bit must make the count of ones over the data bits and the parity bit even when even_sel=1, and odd when even_sel=0. Otherwise parity_err is set.
- R5: With parity_en=1 and stick_par=1, the received parity bit must equal even_sel. Otherwise parity_err is set.
- R6: With parity_en=0, no parity bit is expected: the stop bit follows the last data bit, and parity_err is never set.
- R7: Only the first stop bit is checked. A 0 sampled there sets framing_err. A new start bit may follow the first stop bit at once.
- R8: data_ready goes to 1 when a character completes. A rbr_rd strobe clears it. A lsr_rd strobe leaves it unchanged.
- R9: If a character completes while data_ready is 1 and no rbr_rd arrives in the same cycle, overrun_err is set and the new character replaces the buffer contents.
- R10: break_det is set when the line stays 0 for two full character times. One character time, counted in 16x ticks, is 16 × (start + data + parity + one stop bit). A low stretch of a single frame does not set it.
- R11: A lsr_rd strobe clears parity_err, overrun_err, framing_err and break_det. A new error event in the same cycle wins over the clear.
- R12: line_err_irq is 1 exactly while at least one of parity_err, overrun_err, framing_err or break_det is 1.
- R13: With loopback_en=1 the receiver takes loop_tx as its line and ignores rx_pin.
- R14: The 16x tick fires once every `divisor` clocks, and a divisor of 0 behaves as 1. One bit lasts 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | External serial input (asynchronous) |
| loop_tx | input | 1 | Local transmitter output, for loopback |
| loopback_en | input | 1 | Selects loop_tx as the receive line |
| divisor | input | 16 | Clocks per 16x tick |
| char_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| even_sel | input | 1 | Even parity, or forced parity value |
| stick_par | input | 1 | Forced parity mode |
| rbr_rd | input | 1 | Read strobe on the receive buffer |
| lsr_rd | input | 1 | Read strobe on the line status register |
| rx_data | output | 8 | Received character, right-aligned |
| data_ready | output | 1 | Unread character present |
| parity_err | output | 1 | Parity error flag |
| overrun_err | output | 1 | Overrun flag |
| framing_err | output | 1 | Framing error flag |
| break_det | output | 1 | Break detected flag |
| line_err_irq | output | 1 | Any error or break flag set |

## Verification
The assertions assume that rbr_rd and lsr_rd are single-cycle strobes from the register decode. They also assume that divisor and the frame control fields stay constant while a frame or a break is on the line, so that the character time and the bit sample points are well defined. The bench keeps to this: it changes the configuration only when the line has been idle for at least two bit times, and it pulses each strobe for exactly one clock between frames. Its random frames vary the data, length, parity mode, divisor and the choice of a bad parity or stop bit. Directed cases cover overrun, break, glitches, loopback and a back-to-back start bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int OVS = 16;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } rx_char_t;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = (divisor == '0) ? '0 : divisor - DIV_W'(1);
    tick  = (cnt_q >= lim);
    cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[0] <= 1'b1;
          else        st_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[i] <= 1'b1;
          else        st_q[i] <= st_q[i-1];
        end
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       even_sel,
  input  logic       stick_par,
  output logic       done,
  output rx_char_t   char_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);

  rx_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [2:0]      idx_q, idx_d;
  logic [7:0]      sh_q, sh_d;
  logic            pb_q, pb_d;
  logic            prev_q;
  logic            done_q, done_d;
  rx_char_t        chr_q, chr_d;
  logic            fall, at_mid;
  logic [7:0]      aligned;
  logic            par_bad;

  always_comb begin
    fall    = prev_q & ~line;
    at_mid  = tick && (cnt_q == FULL_M1);
    aligned = sh_q >> (2'd3 - char_len);
    par_bad = stick_par ? (pb_q != even_sel) : ((^aligned) ^ pb_q ^ ~even_sel);

    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pb_d   = pb_q;
    done_d = 1'b0;
    chr_d  = chr_q;

    unique case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == HALF_M1) begin
            cnt_d = '0;
            idx_d = '0;
            sh_d  = '0;
            st_d  = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      RX_DATA: begin
        if (at_mid) begin
          cnt_d = '0;
          sh_d  = {line, sh_q[7:1]};
          if (idx_q == {1'b0, char_len} + 3'd4) st_d = parity_en ? RX_PAR : RX_STOP;
          else                                  idx_d = idx_q + 3'd1;
        end else if (tick) begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      RX_PAR: begin
        if (at_mid) begin
          cnt_d = '0;
          pb_d  = line;
          st_d  = RX_STOP;
        end else if (tick) begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      RX_STOP: begin
        if (at_mid) begin
          cnt_d       = '0;
          done_d      = 1'b1;
          chr_d.data  = aligned;
          chr_d.perr  = parity_en & par_bad;
          chr_d.ferr  = ~line;
          st_d        = RX_IDLE;
        end else if (tick) begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pb_q   <= 1'b0;
      prev_q <= 1'b1;
      done_q <= 1'b0;
      chr_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pb_q   <= pb_d;
      prev_q <= line;
      done_q <= done_d;
      chr_q  <= chr_d;
    end
  end

  assign done   = done_q;
  assign char_o = chr_q;
endmodule

// File: rtl/rx_break.sv
module rx_break
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  output logic       brk_set
);
  localparam int BW = $clog2(2 * OVS * 12 + 1);

  logic [BW-1:0] low_q, low_d, thr;

  always_comb begin
    thr     = BW'(2 * OVS * (7 + int'(char_len) + int'(parity_en)));
    brk_set = tick && !line && (low_q == thr - BW'(1));
    if (line)                          low_d = '0;
    else if (tick && (low_q != thr))   low_d = low_q + BW'(1);
    else                               low_d = low_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= low_d;
  end
endmodule

// File: rtl/rx_status.sv
module rx_status
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  rx_char_t   char_i,
  input  logic       brk_set,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  output logic [7:0] data,
  output logic       dr,
  output logic       pe,
  output logic       oe,
  output logic       fe,
  output logic       bi
);
  logic [7:0] buf_q, buf_d;
  logic dr_q, dr_d, pe_q, pe_d, oe_q, oe_d, fe_q, fe_d, bi_q, bi_d;

  always_comb begin
    buf_d = done ? char_i.data : buf_q;
    dr_d  = done ? 1'b1 : (rbr_rd ? 1'b0 : dr_q);
    oe_d  = (done && dr_q && !rbr_rd) ? 1'b1 : (lsr_rd ? 1'b0 : oe_q);
    pe_d  = (done && char_i.perr)     ? 1'b1 : (lsr_rd ? 1'b0 : pe_q);
    fe_d  = (done && char_i.ferr)     ? 1'b1 : (lsr_rd ? 1'b0 : fe_q);
    bi_d  = brk_set                   ? 1'b1 : (lsr_rd ? 1'b0 : bi_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      dr_q  <= 1'b0;
      pe_q  <= 1'b0;
      oe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      buf_q <= buf_d;
      dr_q  <= dr_d;
      pe_q  <= pe_d;
      oe_q  <= oe_d;
      fe_q  <= fe_d;
      bi_q  <= bi_d;
    end
  end

  assign data = buf_q;
  assign dr   = dr_q;
  assign pe   = pe_q;
  assign oe   = oe_q;
  assign fe   = fe_q;
  assign bi   = bi_q;
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import serial_rx_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_pin,
  input  logic             loop_tx,
  input  logic             loopback_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic             parity_en,
  input  logic             even_sel,
  input  logic             stick_par,
  input  logic             rbr_rd,
  input  logic             lsr_rd,
  output logic [7:0]       rx_data,
  output logic             data_ready,
  output logic             parity_err,
  output logic             overrun_err,
  output logic             framing_err,
  output logic             break_det,
  output logic             line_err_irq
);
  logic     raw_line, sync_line, tick, frm_done, brk_set;
  rx_char_t frm_char;

  assign raw_line = loopback_en ? loop_tx : rx_pin;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_line), .q(sync_line)
  );

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(sync_line),
    .char_len(char_len), .parity_en(parity_en), .even_sel(even_sel),
    .stick_par(stick_par), .done(frm_done), .char_o(frm_char)
  );

  rx_break u_break (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(sync_line),
    .char_len(char_len), .parity_en(parity_en), .brk_set(brk_set)
  );

  rx_status u_status (
    .clk(clk), .rst_n(rst_n), .done(frm_done), .char_i(frm_char),
    .brk_set(brk_set), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
    .data(rx_data), .dr(data_ready), .pe(parity_err), .oe(overrun_err),
    .fe(framing_err), .bi(break_det)
  );

  assign line_err_irq = parity_err | overrun_err | framing_err | break_det;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic clk,
  input logic rst_n,
  input logic rbr_rd,
  input logic lsr_rd,
  input logic frm_done,
  input logic brk_set,
  input logic data_ready,
  input logic parity_err,
  input logic overrun_err,
  input logic framing_err,
  input logic break_det
);
  // R8: a buffer read with no new character empties the buffer
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !frm_done) |=> !data_ready);

  // R8: a status read alone keeps the character pending
  a_r8_status_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rbr_rd && data_ready) |=> data_ready);

  // R8: data_ready only rises after a completed frame
  a_r8_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(frm_done));

  // R9: completing onto an unread character flags an overrun
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && data_ready && !rbr_rd) |=> overrun_err);

  // R10: a break event shows on the flag next cycle
  a_r10_break_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set |=> break_det);

  // R11: a status read with no new event clears all error flags
  a_r11_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !frm_done && !brk_set) |=>
      !(parity_err || overrun_err || framing_err || break_det));
endmodule

bind serial_rx_top serial_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
  .frm_done(frm_done), .brk_set(brk_set), .data_ready(data_ready),
  .parity_err(parity_err), .overrun_err(overrun_err),
  .framing_err(framing_err), .break_det(break_det)
);

// File: tb/tb_serial_rx_top.sv
`timescale 1ns/1ps
module tb_serial_rx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_pin = 1'b1, loop_tx = 1'b1, loopback_en = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  char_len = 2'd3;
  logic        parity_en = 1'b0, even_sel = 1'b0, stick_par = 1'b0;
  logic        rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0]  rx_data;
  logic        data_ready, parity_err, overrun_err, framing_err, break_det, line_err_irq;

  int checks = 0, failures = 0;
  bit use_loop = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_rx_top dut (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .loop_tx(loop_tx),
    .loopback_en(loopback_en), .divisor(divisor), .char_len(char_len),
    .parity_en(parity_en), .even_sel(even_sel), .stick_par(stick_par),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .rx_data(rx_data),
    .data_ready(data_ready), .parity_err(parity_err),
    .overrun_err(overrun_err), .framing_err(framing_err),
    .break_det(break_det), .line_err_irq(line_err_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clocks();
    return 16 * ((divisor == 16'd0) ? 1 : int'(divisor));
  endfunction

  function automatic logic [7:0] mask_data(input logic [7:0] d);
    return d & 8'((1 << (5 + int'(char_len))) - 1);
  endfunction

  function automatic logic good_parity(input logic [7:0] d);
    if (stick_par) return even_sel;
    return (^mask_data(d)) ^ ~even_sel;
  endfunction

  task automatic drive(input logic v, input int clocks);
    @(negedge clk);
    if (use_loop) loop_tx = v; else rx_pin = v;
    repeat (clocks - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                            input int idle_bits);
    int bc = bit_clocks();
    drive(1'b0, bc);
    for (int i = 0; i < 5 + int'(char_len); i++) drive(d[i], bc);
    if (parity_en) drive(good_parity(d) ^ bad_par, bc);
    drive(~bad_stop, bc);
    if (idle_bits > 0) drive(1'b1, bc * idle_bits);
  endtask

  task automatic pulse_rbr();
    @(negedge clk); rbr_rd = 1'b1;
    @(negedge clk); rbr_rd = 1'b0;
  endtask

  task automatic pulse_lsr();
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
  endtask

  task automatic flush();
    pulse_rbr();
    pulse_lsr();
    @(negedge clk);
  endtask

  task automatic check_char(input logic [7:0] d, input bit epe, input bit efe, input string req);
    chk(data_ready == 1'b1, {req, " data_ready"}, data_ready, 1);
    chk(rx_data == mask_data(d), {req, " data"}, rx_data, mask_data(d));
    chk(parity_err == epe, {req, " parity_err"}, parity_err, epe);
    chk(framing_err == efe, {req, " framing_err"}, framing_err, efe);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk({data_ready, parity_err, overrun_err, framing_err, break_det, line_err_irq} == 6'b0,
        "R1 reset flags", {data_ready, parity_err, overrun_err, framing_err, break_det, line_err_irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(data_ready == 1'b0, "R1 idle after reset", data_ready, 0);

    // R2 / R6: 8 bits, no parity
    send_frame(8'hA5, 1'b0, 1'b0, 2);
    check_char(8'hA5, 0, 0, "R2/R6 8N1");
    flush();

    // R2: 5 bits, upper bits zero
    char_len = 2'd0;
    repeat (40) @(negedge clk);
    send_frame(8'hFF, 1'b0, 1'b0, 2);
    check_char(8'hFF, 0, 0, "R2 5-bit");
    chk(rx_data[7:5] == 3'b0, "R2 upper zero", rx_data, 8'h1F);
    flush();

    // R4: even parity good and bad
    char_len = 2'd3; parity_en = 1'b1; even_sel = 1'b1; stick_par = 1'b0;
    repeat (40) @(negedge clk);
    send_frame(8'h37, 1'b0, 1'b0, 2);
    check_char(8'h37, 0, 0, "R4 even ok");
    flush();
    send_frame(8'h37, 1'b1, 1'b0, 2);
    check_char(8'h37, 1, 0, "R4 even bad");
    chk(line_err_irq == 1'b1, "R12 irq on parity", line_err_irq, 1);
    flush();
    chk(line_err_irq == 1'b0, "R12 irq clears", line_err_irq, 0);

    // R5: stick parity, bit must equal even_sel
    stick_par = 1'b1; even_sel = 1'b0; char_len = 2'd2;
    repeat (40) @(negedge clk);
    send_frame(8'h51, 1'b0, 1'b0, 2);
    check_char(8'h51, 0, 0, "R5 stick ok");
    flush();
    send_frame(8'h51, 1'b1, 1'b0, 2);
    check_char(8'h51, 1, 0, "R5 stick bad");
    flush();
    stick_par = 1'b0; parity_en = 1'b0; char_len = 2'd3;
    repeat (40) @(negedge clk);

    // R7: bad stop; then back-to-back frames with one stop bit
    send_frame(8'h3C, 1'b0, 1'b1, 2);
    check_char(8'h3C, 0, 1, "R7 framing");
    chk(break_det == 1'b0, "R10 no break on one frame", break_det, 0);
    flush();
    send_frame(8'h00, 1'b0, 1'b1, 2);
    chk(break_det == 1'b0, "R10 zero frame not break", break_det, 0);
    flush();
    send_frame(8'h12, 1'b0, 1'b0, 0);
    pulse_rbr();
    send_frame(8'h34, 1'b0, 1'b0, 2);
    check_char(8'h34, 0, 0, "R7 back-to-back");
    chk(overrun_err == 1'b0, "R7 no overrun", overrun_err, 0);
    flush();

    // R9 / R8 / R11: overrun
    send_frame(8'h11, 1'b0, 1'b0, 2);
    send_frame(8'h22, 1'b0, 1'b0, 2);
    chk(overrun_err == 1'b1, "R9 overrun set", overrun_err, 1);
    chk(rx_data == 8'h22, "R9 new data kept", rx_data, 8'h22);
    pulse_lsr(); @(negedge clk);
    chk(overrun_err == 1'b0, "R11 lsr clears overrun", overrun_err, 0);
    chk(data_ready == 1'b1, "R8 lsr keeps data_ready", data_ready, 1);
    pulse_rbr(); @(negedge clk);
    chk(data_ready == 1'b0, "R8 rbr clears data_ready", data_ready, 0);

    // R3: glitch ignored
    drive(1'b0, 4 * bit_clocks() / 16);
    drive(1'b1, 3 * bit_clocks());
    chk(data_ready == 1'b0, "R3 glitch ignored", data_ready, 0);

    // R10: break
    parity_en = 1'b1;
    repeat (40) @(negedge clk);
    drive(1'b0, (2 * 16 * 11 + 32) * bit_clocks() / 16);
    chk(break_det == 1'b1, "R10 break set", break_det, 1);
    drive(1'b1, 2 * bit_clocks());
    pulse_lsr(); @(negedge clk);
    chk(break_det == 1'b0, "R11 lsr clears break", break_det, 0);
    flush();
    parity_en = 1'b0;

    // R14: divisor 0 acts as 1, divisor 3
    divisor = 16'd0;
    repeat (40) @(negedge clk);
    send_frame(8'hC3, 1'b0, 1'b0, 2);
    check_char(8'hC3, 0, 0, "R14 divisor 0");
    flush();
    divisor = 16'd3;
    repeat (40) @(negedge clk);
    send_frame(8'h5A, 1'b0, 1'b0, 2);
    check_char(8'h5A, 0, 0, "R14 divisor 3");
    flush();
    divisor = 16'd1;

    // R13: loopback, rx_pin held low and ignored
    loopback_en = 1'b1; use_loop = 1'b1;
    repeat (5) @(negedge clk);
    rx_pin = 1'b0;
    repeat (40) @(negedge clk);
    send_frame(8'h96, 1'b0, 1'b0, 2);
    check_char(8'h96, 0, 0, "R13 loopback");
    chk(break_det == 1'b0, "R13 rx_pin ignored", break_det, 0);
    flush();
    rx_pin = 1'b1;
    repeat (5) @(negedge clk);
    loopback_en = 1'b0; use_loop = 1'b0;
    repeat (40) @(negedge clk);

    // Random frames: R2 R4 R5 R6 R7 R14
    for (int n = 0; n < 24; n++) begin
      logic [7:0] d;
      bit bp, bs;
      divisor   = 16'($urandom_range(1, 3));
      char_len  = 2'($urandom_range(0, 3));
      parity_en = 1'($urandom);
      even_sel  = 1'($urandom);
      stick_par = 1'($urandom);
      d  = 8'($urandom);
      bp = ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 4) == 0);
      repeat (60) @(negedge clk);
      send_frame(d, bp, bs, 2);
      check_char(d, parity_en && bp, bs, "R2/R4/R5/R6/R7 random");
      flush();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule